// File: doc/BRIEF.md
# Timed Transmit Start Sequencer

This block starts the transmission of modulation bits that are waiting in a bit FIFO. A rising edge on the transmit-start input starts two independent delay counters, and both count from that edge. When the first counter expires, the transmit-enable output goes high. When the second counter expires, playout begins: bits leave the FIFO one at a time and appear on the modulation output, each with a single-cycle strobe.

After playout begins, the block takes one bit for every 48 cycles of the reference clock, which gives a symbol rate of 13 MHz / 48. The FIFO can be refilled while playout runs. If a symbol falls due and the FIFO is empty, the output keeps its last bit and a sticky underrun flag is set. Dropping the start input stops the sequence at once.

The FIFO is read in first-word-fall-through form. `fifo_dout` always shows the head bit. A high `fifo_rd` on a clock edge consumes that bit.

Top module: `tx_start_seq`

## Requirements
- R1: A start edge is the first rising `clk` edge at which `tx_start` is sampled high after it was sampled low. Only a start edge launches the two delay counters. Holding `tx_start` low or high does not launch them again.
- R2: `tx_en` goes high on the `clk` edge that comes `en_dly + 1` edges after the start edge. `en_dly` is a 10-bit count from 0 to 1023. `tx_en` then stays high while `tx_start` stays high.
- R3: The first symbol falls due on the edge that comes `play_dly + 1` edges after the start edge. This timing does not depend on `en_dly`.
- R4: Later symbols fall due every 48 `clk` edges after the first one. `mod_vld` is high for exactly the one cycle after each edge on which a bit was popped.
- R5: `fifo_rd` is high only in a cycle whose following edge is a due edge, and only when `fifo_empty` is low. On that edge `mod_bit` takes the value of `fifo_dout`, so bits come out in FIFO order.
- R6: Bits written into the FIFO after playout has started are played out at later due edges.
- R7: When a due edge finds the FIFO empty, nothing is popped, `mod_vld` stays low and `mod_bit` keeps its value. On that edge `underrun` goes high. It stays high until the next start edge clears it. `mod_bit` changes only on a popping edge.
- R8: On every edge at which `tx_start` is sampled low, `tx_en` goes low, playout stops and both counters clear. No bit is popped on that edge.
- R9: While `rst_n` is low, `tx_en`, `mod_bit`, `mod_vld` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (13 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Transmit-start request, level sensitive, launched on its rising edge |
| en_dly | input | 10 | Delay from the start edge to the enable, in clocks |
| play_dly | input | 10 | Delay from the start edge to the first symbol, in clocks |
| fifo_empty | input | 1 | FIFO holds no bit |
| fifo_dout | input | 1 | Head bit of the FIFO (fall-through) |
| fifo_rd | output | 1 | Pop the head bit on this edge |
| tx_en | output | 1 | Internal transmit enable |
| mod_bit | output | 1 | Current modulation bit |
| mod_vld | output | 1 | One-cycle strobe when a new bit appears on `mod_bit` |
| underrun | output | 1 | Sticky flag: a symbol fell due while the FIFO was empty |

## Verification
Some rules hold on every cycle, and the bound assertions check these. A pop never hits an empty FIFO, and every pop produces a single strobe. `mod_bit` changes only on a pop. `underrun` stays set until a start edge. A low `tx_start` clears the enable and the playout. `tx_en` rises only while the start request is present.

The exact positions of the enable edge and of each symbol, counted from the start edge, can only be shown by the bench's scenarios. So can FIFO order, the pickup of bits written during playout, and the edge on which an underrun appears. The bench sweeps a grid of both delays, including the 1023 limit. It computes every expected edge as an offset from the start edge.

// File: rtl/tx_seq_pkg.sv
// Shared constants for the transmit start sequencer.
// Assumes: one timer per delayed action, indexed by the enum below.
package tx_seq_pkg;
    localparam int unsigned DLY_W_DEF   = 10;  // delay counter width
    localparam int unsigned SYM_DIV_DEF = 48;  // reference clocks per symbol
    localparam int unsigned N_TIMERS    = 2;

    typedef enum int unsigned {
        TMR_EN   = 0,  // drives the enable output
        TMR_PLAY = 1   // starts playout
    } tmr_idx_e;
endpackage

// File: rtl/tx_dly_timer.sv
// One-shot delay timer. A load pulse captures the delay value. fire is high
// during the cycle whose following edge is the delay+1-th edge after the load.
// Assumes clr takes priority over load.
module tx_dly_timer #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] dly,
    output logic         fire
);
    logic [W-1:0] cnt;
    logic         run;

    // Count down the loaded delay and stop after firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (clr) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (load) begin
            run <= 1'b1;
            cnt <= dly;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    // Expiry indication for the owner of this timer.
    always_comb fire = run && (cnt == '0);
endmodule

// File: rtl/tx_sym_div.sv
// Symbol-rate divider. It restarts on the start pulse and marks a due edge
// at that pulse and every DIV clocks after it. Assumes DIV >= 2.
module tx_sym_div #(
    parameter int unsigned DIV = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic due
);
    localparam int unsigned CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic             playing;

    // Run the modulo-DIV phase counter while playout is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            playing <= 1'b0;
            cnt     <= '0;
        end else if (clr) begin
            playing <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            playing <= 1'b1;
            cnt     <= '0;
        end else if (playing) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // A symbol is due at the start pulse and at each wrap of the phase.
    always_comb due = !clr && (start || (playing && cnt == LAST));
endmodule

// File: rtl/tx_playout.sv
// Playout stage. On a due edge it pops one bit from a fall-through FIFO,
// or flags underrun when the FIFO is empty. Assumes fifo_dout is valid
// whenever fifo_empty is low.
module tx_playout (
    input  logic clk,
    input  logic rst_n,
    input  logic due,
    input  logic restart,
    input  logic fifo_empty,
    input  logic fifo_dout,
    output logic fifo_rd,
    output logic mod_bit,
    output logic mod_vld,
    output logic underrun
);
    // Pop only when a symbol is due and a bit is waiting.
    always_comb fifo_rd = due && !fifo_empty;

    // Capture the popped bit and raise its strobe; keep the bit otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_bit <= 1'b0;
            mod_vld <= 1'b0;
        end else begin
            mod_vld <= fifo_rd;
            if (fifo_rd) mod_bit <= fifo_dout;
        end
    end

    // Sticky underrun, cleared by a new start edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   underrun <= 1'b0;
        else if (restart)             underrun <= 1'b0;
        else if (due && fifo_empty)   underrun <= 1'b1;
    end
endmodule

// File: rtl/tx_start_seq.sv
// Timed transmit start sequencer (top). It detects the rising edge of
// tx_start, runs two independent delay timers from it (enable and playout),
// and plays out FIFO bits at one per SYM_DIV clocks. A low tx_start aborts.
// Assumes tx_start is synchronous to clk.
module tx_start_seq
    import tx_seq_pkg::*;
#(
    parameter int unsigned DLY_W   = DLY_W_DEF,
    parameter int unsigned SYM_DIV = SYM_DIV_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic [DLY_W-1:0] en_dly,
    input  logic [DLY_W-1:0] play_dly,
    input  logic             fifo_empty,
    input  logic             fifo_dout,
    output logic             fifo_rd,
    output logic             tx_en,
    output logic             mod_bit,
    output logic             mod_vld,
    output logic             underrun
);
    logic             start_q;
    logic             start_rise;
    logic             abort;
    logic             due;
    logic [DLY_W-1:0] dly_sel [N_TIMERS];
    logic [N_TIMERS-1:0] fire;

    // Remember the previous sample of the start request.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= tx_start;
    end

    // Start edge and abort conditions.
    always_comb begin
        start_rise = tx_start && !start_q;
        abort      = !tx_start;
    end

    // Route each delay input to its timer.
    always_comb begin
        dly_sel[TMR_EN]   = en_dly;
        dly_sel[TMR_PLAY] = play_dly;
    end

    for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
        tx_dly_timer #(.W(DLY_W)) tmr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (abort),
            .load  (start_rise),
            .dly   (dly_sel[t]),
            .fire  (fire[t])
        );
    end

    // Enable rises when its timer expires and falls with the request.
    always_ff @(posedge clk) begin
        if (!rst_n)             tx_en <= 1'b0;
        else if (abort)         tx_en <= 1'b0;
        else if (fire[TMR_EN])  tx_en <= 1'b1;
    end

    tx_sym_div #(.DIV(SYM_DIV)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (abort),
        .start (fire[TMR_PLAY]),
        .due   (due)
    );

    tx_playout play_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .due        (due),
        .restart    (start_rise),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .fifo_rd    (fifo_rd),
        .mod_bit    (mod_bit),
        .mod_vld    (mod_vld),
        .underrun   (underrun)
    );
endmodule

// File: rtl/tx_start_seq_chk.sv
// Protocol checker for tx_start_seq, bound to every instance.
// Assumes the same clock and synchronous active-low reset as the block.
module tx_start_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_start,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic tx_en,
    input logic mod_bit,
    input logic mod_vld,
    input logic underrun
);
    assert_start_low_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_start |=> (!tx_en && !mod_vld && !fifo_rd));

    assert_en_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(tx_start));

    assert_no_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    assert_pop_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> mod_vld);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mod_vld |=> !mod_vld);

    assert_bit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_vld |-> $stable(mod_bit));

    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !$rose(tx_start)) |=> underrun);

    assert_underrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(fifo_empty && tx_start));
endmodule

bind tx_start_seq tx_start_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_start   (tx_start),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .tx_en      (tx_en),
    .mod_bit    (mod_bit),
    .mod_vld    (mod_vld),
    .underrun   (underrun)
);

// File: tb/tx_start_seq_tb_top.sv
// Bench for tx_start_seq. It models a fall-through FIFO and computes every
// expected edge as an offset n from the start edge (n = 1 at the start edge).
module tx_start_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_start = 1'b0;
    logic [9:0] en_dly = '0;
    logic [9:0] play_dly = '0;
    logic       fifo_empty;
    logic       fifo_dout;
    logic       fifo_rd, tx_en, mod_bit, mod_vld, underrun;

    always #2 clk = ~clk;

    bit store [0:1023];
    int wr_ptr = 0, rd_ptr = 0;
    assign fifo_empty = (wr_ptr == rd_ptr);
    assign fifo_dout  = store[rd_ptr % 1024];

    int total = 0, bad = 0;
    int n = 0, D = 0, P = 0, seed = 0;
    bit run = 0, pop_prev = 0, under_pend = 0, exp_under = 0, last_bit = 0;

    tx_start_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start),
        .en_dly(en_dly), .play_dly(play_dly),
        .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .fifo_rd(fifo_rd),
        .tx_en(tx_en), .mod_bit(mod_bit), .mod_vld(mod_vld), .underrun(underrun)
    );

    task automatic check(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d n=%0d D=%0d P=%0d", req, act, expv, n, D, P);
        end
    endtask

    function automatic bit is_due(int m);
        return (m >= P + 2) && ((m - P - 2) % 48 == 0);
    endfunction

    task automatic push(int k);
        for (int i = 0; i < k; i++) begin
            store[wr_ptr % 1024] = (((wr_ptr * 7 + seed) % 5) < 2);
            wr_ptr++;
        end
    endtask

    // One clock: apply the model's pop and writes, then check all outputs.
    task automatic step(int push_n);
        bit due_next, exp_pop;
        @(posedge clk);
        if (run) n++;
        @(negedge clk);
        if (pop_prev) begin
            last_bit = store[rd_ptr % 1024];
            rd_ptr++;
        end
        if (run && n == 1) exp_under = 0;  // R7: cleared by the start edge
        if (under_pend) exp_under = 1;
        push(push_n);                       // R6: writes during playout
        #1;
        check(tx_en === (run && n >= D + 2), "R2 tx_en", int'(tx_en), int'(run && n >= D + 2));
        check(mod_vld === pop_prev, "R4 mod_vld", int'(mod_vld), int'(pop_prev));
        check(mod_bit === last_bit, "R5 mod_bit", int'(mod_bit), int'(last_bit));
        check(underrun === exp_under, "R7 underrun", int'(underrun), int'(exp_under));
        due_next = run && is_due(n + 1);
        exp_pop  = due_next && (wr_ptr != rd_ptr);
        check(fifo_rd === exp_pop, "R3 fifo_rd", int'(fifo_rd), int'(exp_pop));
        under_pend = due_next && (wr_ptr == rd_ptr);
        pop_prev   = exp_pop;
    endtask

    task automatic start_seq(int d, int p);
        D = d; P = p;
        en_dly = 10'(d); play_dly = 10'(p);
        tx_start = 1'b1; run = 1; n = 0;
    endtask

    // R8: drop the request and recompute the model as idle.
    task automatic stop_seq();
        tx_start = 1'b0; run = 0;
        pop_prev = 0; under_pend = 0;
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        check(!tx_en && !mod_vld && !underrun && !mod_bit, "R9 reset",
              int'({tx_en, mod_vld, underrun, mod_bit}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: no start edge, FIFO full of bits, nothing may happen
        seed = 1; push(3);
        for (int i = 0; i < 60; i++) step(0);

        // Sweep both delays; R6 refill during playout, R7 underrun at the end
        foreach (D_SET[a]) begin
            foreach (P_SET[b]) begin
                rd_ptr = wr_ptr;
                seed = a * 10 + b;
                push(3);
                start_seq(D_SET[a], P_SET[b]);
                for (int i = 0; i < P_SET[b] + 2 + 48 * 5 + 2; i++)
                    step((n == P_SET[b] + 30) ? 2 : 0);
                stop_seq();
                for (int i = 0; i < 3; i++) step(0);
            end
        end

        // R2, R3 boundary: both delays at the maximum count
        rd_ptr = wr_ptr; seed = 77; push(2);
        start_seq(1023, 1023);
        for (int i = 0; i < 1023 + 2 + 50; i++) step(0);
        stop_seq();
        for (int i = 0; i < 3; i++) step(0);

        // R8: abort in mid-playout with bits still waiting, then R1 restart
        rd_ptr = wr_ptr; seed = 5; push(10);
        start_seq(2, 4);
        for (int i = 0; i < 100; i++) step(0);
        stop_seq();
        for (int i = 0; i < 100; i++) step(0);
        start_seq(6, 1);
        for (int i = 0; i < 150; i++) step(0);
        stop_seq();
        step(0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    int D_SET [4] = '{0, 1, 3, 7};
    int P_SET [3] = '{0, 2, 5};
endmodule